// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register

This block holds the status and configuration bits of a serial NOR flash device. Other logic decodes commands and presents them here: an opcode strobe, a register-write strobe with a 16-bit data word, the state of the write-enable latch, requests to enter and leave high-performance mode, and a power-cycle event. The block stores the bits and applies the update rule that belongs to each one. It presents the assembled 16-bit word for register reads. It also drives the pin-mode select for the two shared pins, the write-protect flag for the security registers and the protect-complement bit that the protection decoder uses.

There are three kinds of bit. The quad-enable and protect-complement bits are non-volatile and keep their values when the power-cycle event arrives. The security lock bit is one-time programmable: once it is set, nothing clears it. The suspend flag and the high-performance flag are volatile. Commands drive them, and a power cycle clears them. Every update appears on the outputs one clock after its strobe. A read returns the word in the same cycle as the request.

Top module: `flash_status_reg`

## Requirements
- R1: While reset is active, and after it is released, every stored bit is 0. The word read is then 0 and quad_sel, sec_wp and prot_cmp are low.
- R2: When reg_wr is high with wel high, the written word sets the quad-enable bit from wdata[9] and the protect-complement bit from wdata[14] at the next clock. When wel is low, reg_wr changes no bit.
- R3: quad_sel equals the quad-enable bit (word bit 9). A 1 means the shared pins carry data lines IO2/IO3. A 0 means they serve as write-protect and hold inputs.
- R4: The security lock (word bit 10) is set by an enabled write that carries 1 at bit 10. An enabled write that carries 0 there leaves the lock unchanged. sec_wp equals the lock.
- R5: Once the lock is 1, it stays 1 through every later write and power-cycle event until the asynchronous reset.
- R6: cmd_valid with opcode 0x75 sets the suspend flag (word bit 15) at the next clock. Opcode 0x7A clears it. Other opcodes leave it unchanged.
- R7: hpm_enter sets the high-performance flag (word bit 13) and hpm_exit clears it. When both are high in the same cycle, hpm_exit wins.
- R8: A pwr_cycle pulse clears the suspend and high-performance flags. It keeps the quad-enable, protect-complement and lock bits, and no write, opcode or mode request takes effect in the same cycle.
- R9: Written data at bits 15 and 13 and at bits 0-8, 11 and 12 is ignored. Those bits read as 0 except bits 15 and 13, which read as their flags.
- R10: With rd_req high, rd_data shows the current word in the same cycle. With rd_req low, rd_data is 0.
- R11: prot_cmp equals the protect-complement bit (word bit 14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 8 | Opcode of the strobed command |
| reg_wr | input | 1 | Register-write strobe |
| wel | input | 1 | Write-enable latch state |
| reg_wdata | input | 16 | Data word of the register write |
| hpm_enter | input | 1 | Request to enter high-performance mode |
| hpm_exit | input | 1 | Request to leave high-performance mode |
| pwr_cycle | input | 1 | Power-down/power-up event pulse |
| rd_req | input | 1 | Register read request |
| rd_data | output | 16 | Register word, valid while rd_req is high |
| quad_sel | output | 1 | Shared pins act as IO2/IO3 when high |
| sec_wp | output | 1 | Security registers write-protected |
| prot_cmp | output | 1 | Protect-complement bit |

## Verification
The assertions assume that every strobe input holds a defined level at each clock edge and lasts a single cycle per event. They also assume that the opcode is meaningful only while cmd_valid is high. The bench drives all inputs at the falling edge, so each is stable at the rising edge. It issues one pulse per step and gives the opcode a random value when no command is strobed. Mixed cycles are deliberate: a write and an opcode together, enter and exit together, and a power cycle with other strobes. These cycles exercise the priority rules the assertions encode.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int WORD_W   = 16;
  localparam int OP_W     = 8;
  localparam int POS_QE   = 9;
  localparam int POS_LOCK = 10;
  localparam int POS_HPF  = 13;
  localparam int POS_CMP  = 14;
  localparam int POS_SUS  = 15;
  localparam logic [OP_W-1:0] OP_SUSPEND = 8'h75;
  localparam logic [OP_W-1:0] OP_RESUME  = 8'h7A;

  typedef struct packed {
    logic qe;
    logic cmp;
    logic lock;
  } nv_bits_t;

  typedef struct packed {
    logic sus;
    logic hpf;
  } vol_bits_t;
endpackage

// File: rtl/fsr_nv_bits.sv
module fsr_nv_bits
  import fsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_req,
  input  logic     wel,
  input  logic     pwr_evt,
  input  logic     wd_qe,
  input  logic     wd_cmp,
  input  logic     wd_lock,
  output nv_bits_t nv_q
);
  nv_bits_t nv_d;
  logic     wr_take;

  assign wr_take = wr_req & wel & ~pwr_evt;

  always_comb begin
    nv_d = nv_q;
    if (wr_take) begin
      nv_d.qe  = wd_qe;
      nv_d.cmp = wd_cmp;
      nv_d.lock = nv_q.lock | wd_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= '0;
    end else if (wr_take) begin
      nv_q <= nv_d;
    end
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_q.lock |=> nv_q.lock);
  // R2
  no_wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(nv_q));
  // R8
  pwr_keeps_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt |=> $stable(nv_q));
  // R4
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wel && !pwr_evt && wd_lock) |=> nv_q.lock);
endmodule

// File: rtl/fsr_vol_bits.sv
module fsr_vol_bits
  import fsr_pkg::*;
#(
  parameter logic [OP_W-1:0] SUSPEND_CODE = OP_SUSPEND,
  parameter logic [OP_W-1:0] RESUME_CODE  = OP_RESUME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            hpm_enter,
  input  logic            hpm_exit,
  input  logic            pwr_evt,
  output vol_bits_t       vol_q
);
  vol_bits_t vol_d;
  logic      is_susp;
  logic      is_resume;

  assign is_susp   = cmd_valid & (cmd_op == SUSPEND_CODE);
  assign is_resume = cmd_valid & (cmd_op == RESUME_CODE);

  always_comb begin
    vol_d = vol_q;
    if (pwr_evt) begin
      vol_d = '0;
    end else begin
      if (is_susp)        vol_d.sus = 1'b1;
      else if (is_resume) vol_d.sus = 1'b0;
      if (hpm_exit)       vol_d.hpf = 1'b0;
      else if (hpm_enter) vol_d.hpf = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q <= '0;
    end else begin
      vol_q <= vol_d;
    end
  end

  // R8
  pwr_clears_vol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt |=> (vol_q == '0));
  // R6
  susp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_evt && cmd_valid && cmd_op == SUSPEND_CODE) |=> vol_q.sus);
  // R6
  resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == RESUME_CODE) |=> !vol_q.sus);
  // R7
  exit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hpm_exit |=> !vol_q.hpf);
endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux
  import fsr_pkg::*;
(
  input  nv_bits_t          nv,
  input  vol_bits_t         vol,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word           = '0;
    word[POS_QE]   = nv.qe;
    word[POS_LOCK] = nv.lock;
    word[POS_CMP]  = nv.cmp;
    word[POS_HPF]  = vol.hpf;
    word[POS_SUS]  = vol.sus;
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_gate
    assign rd_data[b] = word[b] & rd_req;
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              reg_wr,
  input  logic              wel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              hpm_enter,
  input  logic              hpm_exit,
  input  logic              pwr_cycle,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              quad_sel,
  output logic              sec_wp,
  output logic              prot_cmp
);
  localparam logic [WORD_W-1:0] USED_MASK =
    WORD_W'((1 << POS_QE) | (1 << POS_LOCK) | (1 << POS_CMP));

  logic [1:0] rst_pipe;
  logic       core_rst_n;
  nv_bits_t   nv_q;
  vol_bits_t  vol_q;
  logic       unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[1];

  assign unused_wdata = ^(reg_wdata & ~USED_MASK);

  fsr_nv_bits u_nv (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_req  (reg_wr),
    .wel     (wel),
    .pwr_evt (pwr_cycle),
    .wd_qe   (reg_wdata[POS_QE]),
    .wd_cmp  (reg_wdata[POS_CMP]),
    .wd_lock (reg_wdata[POS_LOCK]),
    .nv_q    (nv_q)
  );

  fsr_vol_bits u_vol (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .hpm_enter (hpm_enter),
    .hpm_exit  (hpm_exit),
    .pwr_evt   (pwr_cycle),
    .vol_q     (vol_q)
  );

  fsr_read_mux u_rd (
    .nv      (nv_q),
    .vol     (vol_q),
    .rd_req  (rd_req),
    .rd_data (rd_data)
  );

  assign quad_sel = nv_q.qe;
  assign sec_wp   = nv_q.lock;
  assign prot_cmp = nv_q.cmp;

  // R10
  rd_lock_match_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    rd_req |-> (rd_data[POS_LOCK] == sec_wp && rd_data[POS_QE] == quad_sel
                && rd_data[POS_CMP] == prot_cmp));
  // R9
  rd_unmodelled_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_data & ~(USED_MASK | WORD_W'((1 << POS_SUS) | (1 << POS_HPF)))) == '0);
endmodule

// File: tb/flash_status_reg_test.sv
module flash_status_reg_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, reg_wr, wel, hpm_enter, hpm_exit, pwr_cycle, rd_req;
  logic [7:0]  cmd_op;
  logic [15:0] reg_wdata;
  logic [15:0] rd_data;
  logic        quad_sel, sec_wp, prot_cmp;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  bit m_qe, m_cmp, m_lock, m_sus, m_hpf;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_reg uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .reg_wr(reg_wr), .wel(wel), .reg_wdata(reg_wdata), .hpm_enter(hpm_enter),
    .hpm_exit(hpm_exit), .pwr_cycle(pwr_cycle), .rd_req(rd_req),
    .rd_data(rd_data), .quad_sel(quad_sel), .sec_wp(sec_wp), .prot_cmp(prot_cmp)
  );

  function automatic logic [15:0] model_word();
    logic [15:0] w = '0;
    w[9] = m_qe; w[10] = m_lock; w[13] = m_hpf; w[14] = m_cmp; w[15] = m_sus;
    return w;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_op = $urandom; reg_wr = 0; wel = 0; reg_wdata = $urandom;
    hpm_enter = 0; hpm_exit = 0; pwr_cycle = 0; rd_req = 0;
  endtask

  // one cycle, called at a falling edge
  task automatic step(string req, bit cv, logic [7:0] op, bit wr, bit we,
                      logic [15:0] wd, bit en, bit ex, bit pw, bit rd);
    cmd_valid = cv; cmd_op = op; reg_wr = wr; wel = we; reg_wdata = wd;
    hpm_enter = en; hpm_exit = ex; pwr_cycle = pw; rd_req = rd;
    #1;
    check({req, " R10 same-cycle read"}, rd_data, rd ? model_word() : 16'h0);
    if (pw) begin
      m_sus = 0; m_hpf = 0;
    end else begin
      if (wr && we) begin
        m_qe = wd[9]; m_cmp = wd[14];
        if (wd[10]) m_lock = 1;
      end
      if (cv && op == 8'h75) m_sus = 1;
      else if (cv && op == 8'h7A) m_sus = 0;
      if (ex) m_hpf = 0;
      else if (en) m_hpf = 1;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    rd_req = 1;
    #1;
    check({req, " word"}, rd_data, model_word());
    check({req, " R3 quad_sel"}, {15'h0, quad_sel}, {15'h0, m_qe});
    check({req, " R4 sec_wp"}, {15'h0, sec_wp}, {15'h0, m_lock});
    check({req, " R11 prot_cmp"}, {15'h0, prot_cmp}, {15'h0, m_cmp});
    rd_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    m_qe = 0; m_cmp = 0; m_lock = 0; m_sus = 0; m_hpf = 0;
    repeat (3) @(negedge clk);
    rd_req = 1; #1;
    check("R1 reset word", rd_data, 16'h0);
    check("R1 reset pins", {13'h0, quad_sel, sec_wp, prot_cmp}, 16'h0);
    rd_req = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd_req = 1; #1;
    check("R1 after release", rd_data, 16'h0);
    rd_req = 0;

    // R2 write without wel is ignored
    step("R2 no wel", 0, 8'h00, 1, 0, 16'hFFFF, 0, 0, 0, 0);
    // R2 enabled write, R9 ignored bits (15,13 and unmodelled set)
    step("R2 R9 write", 0, 8'h00, 1, 1, 16'hBBFF & ~16'h0400 | 16'h4200, 0, 0, 0, 1);
    step("R3 clear qe", 0, 8'h00, 1, 1, 16'h4000, 0, 0, 0, 0);
    step("R3 set qe", 0, 8'h00, 1, 1, 16'h0200, 0, 0, 0, 1);
    // R6 suspend, other opcode, resume
    step("R6 suspend", 1, 8'h75, 0, 0, 16'h0, 0, 0, 0, 0);
    step("R6 other op", 1, 8'h05, 0, 0, 16'h0, 0, 0, 0, 1);
    step("R6 op no valid", 0, 8'h7A, 0, 0, 16'h0, 0, 0, 0, 0);
    step("R6 resume", 1, 8'h7A, 0, 0, 16'h0, 0, 0, 0, 1);
    // R7
    step("R7 enter", 0, 8'h00, 0, 0, 16'h0, 1, 0, 0, 0);
    step("R7 both", 0, 8'h00, 0, 0, 16'h0, 1, 1, 0, 1);
    step("R7 enter again", 0, 8'h00, 0, 0, 16'h0, 1, 0, 0, 0);
    step("R6 suspend w/ write", 1, 8'h75, 1, 1, 16'h4200, 0, 0, 0, 1);
    // R8 power cycle blocks strobes, clears volatile
    step("R8 pwr", 1, 8'h7A, 1, 1, 16'h0400, 1, 0, 1, 1);
    step("R8 re-set", 1, 8'h75, 0, 0, 16'h0, 1, 0, 0, 0);
    step("R8 pwr plain", 0, 8'h00, 0, 0, 16'h0, 0, 0, 1, 0);
    // R4 lock set, R5 sticky
    step("R4 lock set", 0, 8'h00, 1, 1, 16'h0400, 0, 0, 0, 1);
    step("R4 write zero", 0, 8'h00, 1, 1, 16'h0000, 0, 0, 0, 1);
    step("R5 pwr keeps lock", 0, 8'h00, 0, 0, 16'h0, 0, 0, 1, 0);
    step("R5 more writes", 0, 8'h00, 1, 1, 16'h4200, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op = (i % 3 == 0) ? 8'h75 : ((i % 3 == 1) ? 8'h7A : 8'($urandom));
      step("mixed", 1'($urandom), op, 1'($urandom), 1'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), (i % 7 == 6), 1'($urandom));
    end
    check("R5 lock final", {15'h0, sec_wp}, 16'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule